// File: doc/BRIEF.md
# Multiblock Chain Link Controller

This block is the control logic of one slave in a chain of slaves that together answer one long block read from a bus master. Only one slave serves data at a time. When it has nothing left, it hands a token to the next slave downstream. While that handover is in progress it holds the shared wait line high, so the master does not move on. A role input picks primary, middle or end behaviour. The primary is the slave the master addresses at its multiblock register. Middle and end slaves join when the token reaches them. The end slave closes the read by reporting an empty buffer.

The controller follows the address strobe, the data strobe level and the mode code. It answers each data strobe transition with a matching level on its data acknowledge output. While it is the active slave it also drives a data word, a parity bit and a two-bit status. A small counter-based word source stands in for each slave's buffer. That source gives a fixed number of words, starting at a base value. The slave giving up the token arranges the data acknowledge line so that the incoming slave's first transfer keeps the acknowledge in step with the strobe. The read ends when the master drops the address strobe or switches to a secondary address operation. A middle or end slave then keeps wait high for a short cleanup time.

All outputs are registered. An input change seen at one rising clock edge shows on the outputs after that same edge.

Top module: `mb_link_ctrl`

## Requirements
- R1: Synchronous reset leaves `wait_o`, `tok_out_o`, `dk_o`, `ss_o`, `data_o` and `par_o` at 0. `tka_out_o` resets to 1 for the primary (role 0) and end (role 2) roles, and to the value of `tka_in_i` for the middle (role 1) role.
- R2: A primary link with `as_i` high enters multiblock mode on `mb_sel_i`, with `dk_o` taking the level of `ds_i`. After that, each `ds_i` transition makes the next edge drive `dk_o` equal to `ds_i`, `ss_o`=0, `data_o` = BASE + n for the n-th word (counting from 0), and `par_o` = XOR of the `data_o` bits.
- R3: On the first `ds_i` transition after its last word, an active primary or middle link drives `data_o`, `par_o` and `ss_o` to 0, sets `wait_o` and `tok_out_o` to 1, and leaves `dk_o` unchanged.
- R4: An active primary or middle link that sees a `ds_i` transition while `tka_in_i` is 0 and `tok_out_o` is 0 answers with `ss_o`=3, `data_o`=0 and `dk_o` equal to `ds_i`.
- R5: A middle or end link with `as_i` high drives `tka_out_o` to 0 on the PREP_CYC-th clock edge after the edge that sees `tok_in_i` rise.
- R6: A link waiting after passing the token clears `wait_o` at the edge that sees `tka_in_i` fall.
- R7: Once `tka_out_o` is 0, a new link waits for `wt_bus_i` to be 0. It then serves its first word, with `dk_o` equal to the current `ds_i` level.
- R8: A passing link whose `dk_o` is 1 when it clears wait drives `dk_o` to 0 one edge later. After the handover it ignores `ds_i` transitions: `dk_o` and `data_o` stay 0.
- R9: An end link with no words left answers each `ds_i` transition with `ss_o`=2, `data_o`=0 and `dk_o` equal to `ds_i`.
- R10: On a fall of `as_i`, a primary link drives `tok_out_o`, `wait_o`, `dk_o`, `ss_o` and `data_o` to 0.
- R11: On a fall of `as_i` while in multiblock mode, a middle or end link sets `wait_o` to 1 and drives `tok_out_o`, `dk_o`, `ss_o` and `data_o` to 0. It sets `tka_out_o` to `tka_in_i` (middle) or to 1 (end), and clears `wait_o` CLEAN_CYC edges later.
- R12: A rising `ds_i` with `ms_i` equal to SEC_CODE ends multiblock mode. A primary link drops `tok_out_o` and keeps answering `ds_i` transitions with `dk_o`=`ds_i` and `ss_o`=0. A middle or end link drops `tok_out_o`, sets `tka_out_o` as in R11, and drives `dk_o`, `ss_o` and `data_o` to 0, without raising `wait_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| role_i | input | 2 | 0 primary, 1 middle, 2 end |
| as_i | input | 1 | Address strobe from the master, high while attached |
| ds_i | input | 1 | Data strobe level from the master |
| ms_i | input | MS_W | Mode code of the current operation |
| mb_sel_i | input | 1 | Strobe: link addressed at its multiblock register |
| tok_in_i | input | 1 | Token from the upstream link |
| tka_in_i | input | 1 | Token acknowledge from the downstream link |
| wt_bus_i | input | 1 | Combined wait line as seen on the bus |
| wait_o | output | 1 | This link's wait drive |
| dk_o | output | 1 | Data acknowledge drive |
| ss_o | output | 2 | Status: 0 ok, 2 empty, 3 error |
| data_o | output | DW | Data word |
| par_o | output | 1 | XOR parity of data_o |
| tok_out_o | output | 1 | Token to the downstream link |
| tka_out_o | output | 1 | Token acknowledge to the upstream link |

## Verification
The hardest situation to reach is the handover itself. A link must run dry, raise wait and token-out, and then see the acknowledge fall. Only after that can the acknowledge drop that the incoming link depends on be observed. The bench reaches it by playing the neighbours on the single link under test. It drives the strobe transitions needed to use up the word source, and it chooses the strobe level at exhaustion so that the previous link is left holding the acknowledge high. Then it lowers token-acknowledge-in. The opposite side is reached by raising token-in on a middle or end link and holding the bus wait line high across the ready delay. The first-word strobe level is set low in one test and high in another.

// File: rtl/mb_link_pkg.sv
package mb_link_pkg;

  localparam logic [1:0] ROLE_PRI = 2'd0;
  localparam logic [1:0] ROLE_MID = 2'd1;
  localparam logic [1:0] ROLE_END = 2'd2;

  localparam logic [1:0] SS_OK    = 2'd0;
  localparam logic [1:0] SS_EMPTY = 2'd2;
  localparam logic [1:0] SS_ERR   = 2'd3;

  // bit positions of the sampled input history vector
  localparam int H_AS  = 3;
  localparam int H_DS  = 2;
  localparam int H_TOK = 1;
  localparam int H_TKA = 0;
  localparam int H_W   = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ACT,    // serving data cycles
    ST_PASS,   // token handed on, holding wait
    ST_DROP,   // release dk after wait cleared
    ST_DONE,   // spectator until detach
    ST_PREP,   // token received, preparing
    ST_PEND,   // ready, waiting for bus wait to clear
    ST_CLEAN,  // detach cleanup with wait held
    ST_SOLO    // primary alone after secondary address
  } mb_state_e;

endpackage

// File: rtl/mb_edge.sv
module mb_edge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] prev_o
);

  for (genvar b = 0; b < N; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) prev_o[b] <= 1'b0;
      else     prev_o[b] <= sig_i[b];
    end
  end

endmodule

// File: rtl/mb_word_src.sv
module mb_word_src #(
  parameter int              DW        = 16,
  parameter int              BLK_WORDS = 3,
  parameter logic [DW-1:0]   BASE      = 'h100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [DW-1:0] word_o,
  output logic          par_o,
  output logic          empty_o
);

  localparam int IW = $clog2(BLK_WORDS + 1);
  localparam logic [IW-1:0] LAST = IW'(BLK_WORDS);

  logic [IW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)                 idx_q <= '0;
    else if (adv_i && idx_q != LAST)  idx_q <= idx_q + 1'b1;
  end

  always_comb begin
    word_o  = BASE + DW'(idx_q);
    par_o   = ^word_o;
    empty_o = (idx_q == LAST);
  end

endmodule

// File: rtl/mb_link_fsm.sv
module mb_link_fsm
  import mb_link_pkg::*;
#(
  parameter int            DW        = 16,
  parameter int            MS_W      = 3,
  parameter logic [MS_W-1:0] SEC_CODE = 'd5,
  parameter int            PREP_CYC  = 2,
  parameter int            CLEAN_CYC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      role_i,
  input  logic            as_i,
  input  logic            ds_i,
  input  logic [MS_W-1:0] ms_i,
  input  logic            mb_sel_i,
  input  logic            tok_in_i,
  input  logic            tka_in_i,
  input  logic            wt_bus_i,
  input  logic [H_W-1:0]  hist_i,
  input  logic [DW-1:0]   word_i,
  input  logic            wpar_i,
  input  logic            empty_i,
  output logic            src_clr_o,
  output logic            src_adv_o,
  output logic            wait_o,
  output logic            dk_o,
  output logic [1:0]      ss_o,
  output logic [DW-1:0]   data_o,
  output logic            par_o,
  output logic            tok_out_o,
  output logic            tka_out_o
);

  localparam int CNT_MAX = (PREP_CYC > CLEAN_CYC) ? PREP_CYC : CLEAN_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] PREP_LAST  = CW'(PREP_CYC - 1);
  localparam logic [CW-1:0] CLEAN_LAST = CW'(CLEAN_CYC - 1);

  mb_state_e     state_q;
  logic [CW-1:0] cnt_q;

  logic is_pri, is_mid, is_end;
  logic ds_edge, ds_rise, as_fall, tok_rise, tka_fall;
  logic in_mb, detach, sec_hit, enter_pri, enter_tok;
  logic err_hit, first_serve, norm_serve, tka_idle;

  always_comb begin
    is_pri   = (role_i == ROLE_PRI);
    is_mid   = (role_i == ROLE_MID);
    is_end   = !is_pri && !is_mid;
    ds_rise  = ds_i && !hist_i[H_DS];
    ds_edge  = ds_i ^ hist_i[H_DS];
    as_fall  = !as_i && hist_i[H_AS];
    tok_rise = tok_in_i && !hist_i[H_TOK];
    tka_fall = !tka_in_i && hist_i[H_TKA];
    tka_idle = is_mid ? tka_in_i : 1'b1;

    in_mb = (state_q == ST_ACT)  || (state_q == ST_PASS) ||
            (state_q == ST_DROP) || (state_q == ST_DONE) ||
            (state_q == ST_PREP) || (state_q == ST_PEND);

    detach    = as_fall && (in_mb || state_q == ST_SOLO);
    sec_hit   = !detach && in_mb && ds_rise && (ms_i == SEC_CODE);
    enter_pri = is_pri && (state_q == ST_IDLE) && mb_sel_i && as_i;
    enter_tok = !is_pri && (state_q == ST_IDLE) && tok_rise && as_i;
    err_hit   = (state_q == ST_ACT) && ds_edge && !is_end &&
                !tka_in_i && !tok_out_o;
    first_serve = (state_q == ST_PEND) && !wt_bus_i;
    norm_serve  = (state_q == ST_ACT) && ds_edge && !err_hit && !empty_i;

    src_clr_o = !detach && !sec_hit && (enter_pri || enter_tok);
    src_adv_o = !detach && !sec_hit && (first_serve || norm_serve);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      wait_o    <= 1'b0;
      dk_o      <= 1'b0;
      ss_o      <= SS_OK;
      data_o    <= '0;
      par_o     <= 1'b0;
      tok_out_o <= 1'b0;
      tka_out_o <= (role_i == ROLE_MID) ? tka_in_i : 1'b1;
    end else if (detach) begin
      dk_o      <= 1'b0;
      ss_o      <= SS_OK;
      data_o    <= '0;
      par_o     <= 1'b0;
      tok_out_o <= 1'b0;
      tka_out_o <= tka_idle;
      cnt_q     <= '0;
      if (is_pri) begin
        wait_o  <= 1'b0;
        state_q <= ST_IDLE;
      end else begin
        wait_o  <= 1'b1;
        state_q <= ST_CLEAN;
      end
    end else if (sec_hit) begin
      tok_out_o <= 1'b0;
      wait_o    <= 1'b0;
      ss_o      <= SS_OK;
      data_o    <= '0;
      par_o     <= 1'b0;
      if (is_pri) begin
        dk_o    <= ds_i;
        state_q <= ST_SOLO;
      end else begin
        dk_o      <= 1'b0;
        tka_out_o <= tka_idle;
        state_q   <= ST_IDLE;
      end
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          tka_out_o <= tka_idle;
          if (enter_pri) begin
            dk_o    <= ds_i;
            ss_o    <= SS_OK;
            state_q <= ST_ACT;
          end else if (enter_tok) begin
            cnt_q   <= '0;
            state_q <= ST_PREP;
          end
        end
        ST_PREP: begin
          if (cnt_q == PREP_LAST) begin
            tka_out_o <= 1'b0;
            state_q   <= ST_PEND;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PEND: begin
          if (first_serve) begin
            data_o  <= word_i;
            par_o   <= wpar_i;
            ss_o    <= SS_OK;
            dk_o    <= ds_i;
            state_q <= ST_ACT;
          end
        end
        ST_ACT: begin
          if (ds_edge) begin
            if (err_hit) begin
              ss_o   <= SS_ERR;
              dk_o   <= ds_i;
              data_o <= '0;
              par_o  <= 1'b0;
            end else if (empty_i) begin
              data_o <= '0;
              par_o  <= 1'b0;
              if (is_end) begin
                ss_o <= SS_EMPTY;
                dk_o <= ds_i;
              end else begin
                ss_o      <= SS_OK;
                wait_o    <= 1'b1;
                tok_out_o <= 1'b1;
                state_q   <= ST_PASS;
              end
            end else begin
              data_o <= word_i;
              par_o  <= wpar_i;
              ss_o   <= SS_OK;
              dk_o   <= ds_i;
            end
          end
        end
        ST_PASS: begin
          if (tka_fall) begin
            wait_o  <= 1'b0;
            state_q <= dk_o ? ST_DROP : ST_DONE;
          end
        end
        ST_DROP: begin
          dk_o    <= 1'b0;
          state_q <= ST_DONE;
        end
        ST_DONE: begin
        end
        ST_CLEAN: begin
          tka_out_o <= tka_idle;
          if (cnt_q == CLEAN_LAST) begin
            wait_o  <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_SOLO: begin
          if (ds_edge) begin
            dk_o <= ds_i;
            ss_o <= SS_OK;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mb_link_ctrl.sv
module mb_link_ctrl
  import mb_link_pkg::*;
#(
  parameter int              DW        = 16,
  parameter int              BLK_WORDS = 3,
  parameter logic [DW-1:0]   BASE      = 'h100,
  parameter int              MS_W      = 3,
  parameter logic [MS_W-1:0] SEC_CODE  = 'd5,
  parameter int              PREP_CYC  = 2,
  parameter int              CLEAN_CYC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      role_i,
  input  logic            as_i,
  input  logic            ds_i,
  input  logic [MS_W-1:0] ms_i,
  input  logic            mb_sel_i,
  input  logic            tok_in_i,
  input  logic            tka_in_i,
  input  logic            wt_bus_i,
  output logic            wait_o,
  output logic            dk_o,
  output logic [1:0]      ss_o,
  output logic [DW-1:0]   data_o,
  output logic            par_o,
  output logic            tok_out_o,
  output logic            tka_out_o
);

  logic [H_W-1:0] hist;
  logic [H_W-1:0] hist_in;
  logic [DW-1:0]  word;
  logic           wpar, empty, src_clr, src_adv;

  always_comb begin
    hist_in        = '0;
    hist_in[H_AS]  = as_i;
    hist_in[H_DS]  = ds_i;
    hist_in[H_TOK] = tok_in_i;
    hist_in[H_TKA] = tka_in_i;
  end

  mb_edge #(.N(H_W)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .sig_i  (hist_in),
    .prev_o (hist)
  );

  mb_word_src #(.DW(DW), .BLK_WORDS(BLK_WORDS), .BASE(BASE)) u_src (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (src_clr),
    .adv_i   (src_adv),
    .word_o  (word),
    .par_o   (wpar),
    .empty_o (empty)
  );

  mb_link_fsm #(
    .DW(DW), .MS_W(MS_W), .SEC_CODE(SEC_CODE),
    .PREP_CYC(PREP_CYC), .CLEAN_CYC(CLEAN_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .role_i    (role_i),
    .as_i      (as_i),
    .ds_i      (ds_i),
    .ms_i      (ms_i),
    .mb_sel_i  (mb_sel_i),
    .tok_in_i  (tok_in_i),
    .tka_in_i  (tka_in_i),
    .wt_bus_i  (wt_bus_i),
    .hist_i    (hist),
    .word_i    (word),
    .wpar_i    (wpar),
    .empty_i   (empty),
    .src_clr_o (src_clr),
    .src_adv_o (src_adv),
    .wait_o    (wait_o),
    .dk_o      (dk_o),
    .ss_o      (ss_o),
    .data_o    (data_o),
    .par_o     (par_o),
    .tok_out_o (tok_out_o),
    .tka_out_o (tka_out_o)
  );

endmodule

// File: rtl/mb_link_ctrl_chk.sv
module mb_link_ctrl_chk
  import mb_link_pkg::*;
#(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    role_i,
  input logic          as_i,
  input logic          wait_o,
  input logic [1:0]    ss_o,
  input logic [DW-1:0] data_o,
  input logic          tok_out_o,
  input logic          tka_out_o
);

  // R3: while holding wait the link drives no data or status
  assert_wait_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    wait_o |-> (data_o == '0 && ss_o == SS_OK));

  // R3: the token leaves together with wait
  assert_pass_raises_wait_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(tok_out_o) |-> wait_o);

  // R4: the error status only appears before the token was passed
  assert_err_untokened_R4: assert property (@(posedge clk) disable iff (rst)
    (ss_o == SS_ERR) |-> !tok_out_o);

  // R9: the empty status belongs to the end role
  assert_empty_end_only_R9: assert property (@(posedge clk) disable iff (rst)
    (ss_o == SS_EMPTY) |-> (role_i != ROLE_PRI && role_i != ROLE_MID));

  // R10: once detached, no token is offered downstream
  assert_tok_drop_detach_R10: assert property (@(posedge clk) disable iff (rst)
    (!as_i && $past(!as_i)) |-> !tok_out_o);

  // R11: a detached end link keeps its acknowledge-out high
  assert_end_idle_ack_R11: assert property (@(posedge clk) disable iff (rst)
    (role_i == ROLE_END && !as_i && $past(!as_i)) |-> tka_out_o);

endmodule

bind mb_link_ctrl mb_link_ctrl_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .role_i    (role_i),
  .as_i      (as_i),
  .wait_o    (wait_o),
  .ss_o      (ss_o),
  .data_o    (data_o),
  .tok_out_o (tok_out_o),
  .tka_out_o (tka_out_o)
);

// File: tb/sim_mb_link_ctrl.sv
`timescale 1ns/1ps
module sim_mb_link_ctrl;

  localparam int          DW    = 16;
  localparam logic [15:0] BASE  = 16'h100;
  localparam logic [2:0]  SEC   = 3'd5;
  localparam logic [1:0]  PRI   = 2'd0;
  localparam logic [1:0]  MID   = 2'd1;
  localparam logic [1:0]  ENDR  = 2'd2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] role = PRI;
  logic as_s = 0, ds = 0, mb_sel = 0, tok_in = 0, tka_in = 1, wt_bus = 0;
  logic [2:0] ms = '0;
  logic wait_o, dk_o, par_o, tok_out_o, tka_out_o;
  logic [1:0] ss_o;
  logic [DW-1:0] data_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mb_link_ctrl #(
    .DW(DW), .BLK_WORDS(3), .BASE(BASE), .MS_W(3), .SEC_CODE(SEC),
    .PREP_CYC(2), .CLEAN_CYC(3)
  ) u0 (
    .clk(clk), .rst(rst), .role_i(role), .as_i(as_s), .ds_i(ds), .ms_i(ms),
    .mb_sel_i(mb_sel), .tok_in_i(tok_in), .tka_in_i(tka_in), .wt_bus_i(wt_bus),
    .wait_o(wait_o), .dk_o(dk_o), .ss_o(ss_o), .data_o(data_o), .par_o(par_o),
    .tok_out_o(tok_out_o), .tka_out_o(tka_out_o)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_word(input string req, input logic [15:0] w, input logic d);
    check(req, "data", 32'(data_o), 32'(w));
    check(req, "par", 32'(par_o), 32'(^w));
    check(req, "ss", 32'(ss_o), 32'd0);
    check(req, "dk", 32'(dk_o), 32'(d));
  endtask

  task automatic do_reset(input logic [1:0] r, input logic tka);
    rst = 1; role = r; as_s = 0; ds = 0; ms = '0; mb_sel = 0;
    tok_in = 0; tka_in = tka; wt_bus = 0;
    step(); step();
    rst = 0;
    step();
  endtask

  task automatic t_reset();
    do_reset(MID, 1'b0);
    check("R1", "wait", 32'(wait_o), 0);
    check("R1", "tok_out", 32'(tok_out_o), 0);
    check("R1", "dk", 32'(dk_o), 0);
    check("R1", "ss", 32'(ss_o), 0);
    check("R1", "data", 32'(data_o), 0);
    check("R1", "tka_out mid", 32'(tka_out_o), 0);
    do_reset(ENDR, 1'b0);
    check("R1", "tka_out end", 32'(tka_out_o), 1);
    do_reset(PRI, 1'b0);
    check("R1", "tka_out pri", 32'(tka_out_o), 1);
  endtask

  task automatic enter_primary();
    as_s = 1; step();
    mb_sel = 1; step();
    mb_sel = 0;
    check("R2", "dk at entry", 32'(dk_o), 0);
  endtask

  task automatic t_primary_stream();
    do_reset(PRI, 1'b1);
    enter_primary();
    ds = 1; step(); chk_word("R2", BASE + 16'd0, 1'b1);
    ds = 0; step(); chk_word("R2", BASE + 16'd1, 1'b0);
    ds = 1; step(); chk_word("R2", BASE + 16'd2, 1'b1);
    ds = 0; step();
    check("R3", "data", 32'(data_o), 0);
    check("R3", "ss", 32'(ss_o), 0);
    check("R3", "wait", 32'(wait_o), 1);
    check("R3", "tok_out", 32'(tok_out_o), 1);
    check("R3", "dk held", 32'(dk_o), 1);
    step();
    check("R6", "wait before ack", 32'(wait_o), 1);
    tka_in = 0; step();
    check("R6", "wait cleared", 32'(wait_o), 0);
    check("R8", "dk before drop", 32'(dk_o), 1);
    step();
    check("R8", "dk dropped", 32'(dk_o), 0);
    ds = 1; step();
    check("R8", "dk ignored", 32'(dk_o), 0);
    check("R8", "data ignored", 32'(data_o), 0);
    ds = 0; step();
    as_s = 0; step();
    check("R10", "tok_out", 32'(tok_out_o), 0);
    check("R10", "wait", 32'(wait_o), 0);
    check("R10", "data", 32'(data_o), 0);
  endtask

  task automatic t_error();
    do_reset(PRI, 1'b1);
    enter_primary();
    tka_in = 0;
    ds = 1; step();
    check("R4", "ss", 32'(ss_o), 3);
    check("R4", "dk", 32'(dk_o), 1);
    check("R4", "data", 32'(data_o), 0);
    check("R4", "tok_out", 32'(tok_out_o), 0);
    ds = 0; step();
    check("R4", "ss again", 32'(ss_o), 3);
    check("R4", "dk again", 32'(dk_o), 0);
    as_s = 0; tka_in = 1; step();
  endtask

  task automatic t_middle();
    do_reset(MID, 1'b1);
    check("R1", "tka_out mid idle", 32'(tka_out_o), 1);
    as_s = 1; ds = 1; wt_bus = 1; step();
    tok_in = 1; step();
    check("R5", "tka_out edge1", 32'(tka_out_o), 1);
    step();
    check("R5", "tka_out edge2", 32'(tka_out_o), 1);
    step();
    check("R5", "tka_out ready", 32'(tka_out_o), 0);
    step();
    check("R7", "data held off", 32'(data_o), 0);
    check("R7", "dk held off", 32'(dk_o), 0);
    wt_bus = 0; step();
    chk_word("R7", BASE + 16'd0, 1'b1);
    ds = 0; step(); chk_word("R2", BASE + 16'd1, 1'b0);
    ds = 1; step(); chk_word("R2", BASE + 16'd2, 1'b1);
    ds = 0; step();
    check("R3", "mid wait", 32'(wait_o), 1);
    check("R3", "mid tok_out", 32'(tok_out_o), 1);
    tka_in = 0; as_s = 0; step();
    check("R11", "wait", 32'(wait_o), 1);
    check("R11", "tok_out", 32'(tok_out_o), 0);
    check("R11", "tka_out copy", 32'(tka_out_o), 0);
    check("R11", "dk", 32'(dk_o), 0);
    check("R11", "data", 32'(data_o), 0);
    step();
    check("R11", "wait hold1", 32'(wait_o), 1);
    step();
    check("R11", "wait hold2", 32'(wait_o), 1);
    step();
    check("R11", "wait cleared", 32'(wait_o), 0);
    tok_in = 0; tka_in = 1; step();
  endtask

  task automatic t_end();
    do_reset(ENDR, 1'b1);
    as_s = 1; ds = 0; wt_bus = 0; step();
    tok_in = 1; step(); step(); step();
    check("R5", "end tka_out ready", 32'(tka_out_o), 0);
    step();
    chk_word("R7", BASE + 16'd0, 1'b0);
    ds = 1; step(); chk_word("R2", BASE + 16'd1, 1'b1);
    ds = 0; step(); chk_word("R2", BASE + 16'd2, 1'b0);
    ds = 1; step();
    check("R9", "ss", 32'(ss_o), 2);
    check("R9", "dk", 32'(dk_o), 1);
    check("R9", "data", 32'(data_o), 0);
    ds = 0; step();
    check("R9", "ss again", 32'(ss_o), 2);
    check("R9", "dk again", 32'(dk_o), 0);
    ms = SEC; ds = 1; step();
    check("R12", "end tok_out", 32'(tok_out_o), 0);
    check("R12", "end tka_out", 32'(tka_out_o), 1);
    check("R12", "end ss", 32'(ss_o), 0);
    check("R12", "end dk", 32'(dk_o), 0);
    check("R12", "end wait", 32'(wait_o), 0);
    ms = '0; ds = 0; as_s = 0; tok_in = 0; step();
  endtask

  task automatic t_primary_sec();
    do_reset(PRI, 1'b1);
    enter_primary();
    ds = 1; step(); ds = 0; step(); ds = 1; step(); ds = 0; step();
    check("R12", "tok_out before", 32'(tok_out_o), 1);
    tka_in = 0; step(); step();
    ms = SEC; ds = 1; step();
    check("R12", "pri tok_out", 32'(tok_out_o), 0);
    check("R12", "pri dk", 32'(dk_o), 1);
    check("R12", "pri ss", 32'(ss_o), 0);
    check("R12", "pri wait", 32'(wait_o), 0);
    ds = 0; step();
    check("R12", "pri dk solo", 32'(dk_o), 0);
    as_s = 0; ms = '0; tka_in = 1; step();
    check("R10", "solo detach dk", 32'(dk_o), 0);
  endtask

  initial begin
    t_reset();
    t_primary_stream();
    t_error();
    t_middle();
    t_end();
    t_primary_sec();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule